// File: doc/BRIEF.md
# Serial 0101 Sequence Detector

This block watches a one-bit serial stream and flags every place where the four most recent bits, oldest first, read 0, 1, 0, 1. It takes one bit of `x` on each rising clock edge. The flag `z` is a Mealy output: it is high during the cycle in which the current input bit completes the pattern, so it depends on both the stored state and the live value of `x`. Matches may overlap. After a hit, the final 0,1 counts as the start of the next candidate, so the stream 0,1,0,1,0,1 gives two hits.

The machine has four logical states. `DET_IDLE` means no useful prefix has been seen. `DET_SAW0` means the last bit was 0. `DET_SAW01` means the last two bits were 0,1. `DET_SAW010` means the last three bits were 0,1,0. The transitions are as follows:
- IDLE: 0 goes to SAW0, 1 stays in IDLE.
- SAW0: 0 stays in SAW0, 1 goes to SAW01.
- SAW01: 0 goes to SAW010, 1 falls back to IDLE.
- SAW010: 0 goes to SAW0 with no flag, 1 raises `z` and goes to SAW01.

A synchronous active-high reset returns the machine to IDLE. A parameter selects the state code without changing behaviour:
- binary: 00, 01, 10, 11
- Gray: 00, 01, 11, 10
- one-hot: 1000, 0100, 0010, 0001

Top module: `pat0101_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to IDLE. `z` is 0 whenever `rst` is high, even if a match is pending.
- R2: `z` is 1 in the cycle where the current `x` is 1 and the three bits taken at the preceding edges since reset were 0,1,0. Otherwise `z` is 0.
- R3: Matches overlap. In the stream 0,1,0,1,0,1,0 sent right after reset, `z` is high on the 4th and 6th bits only.
- R4: From IDLE, a 1 keeps the machine in IDLE, so leading ones never form part of a match.
- R5: From SAW0, further 0 bits keep it in SAW0. The stream 0,0,0,1,0,1 matches on its 6th bit.
- R6: From SAW01, a 1 returns to IDLE. The stream 0,1,1,0,1 gives no hit, and 0,1,1,0,1,0,1 hits only on the 7th bit.
- R7: From SAW010, a 0 goes to SAW0. The stream 0,1,0,0,1,0,1 hits only on the 7th bit.
- R8: `z` follows `x` combinationally within a cycle. In SAW010, `z` rises and falls with `x` before the next edge.
- R9: The binary (select 0), Gray (select 1) and one-hot (select 2) state codes give identical `z` for any input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is taken per edge |
| rst | input | 1 | Synchronous active-high reset to IDLE |
| x | input | 1 | Serial data bit |
| z | output | 1 | Mealy match flag, high while the current bit completes 0101 |

## Verification
The hardest case is a pending match held in SAW010 at the moment reset arrives. The bench has to walk the stream to 0,1,0, then raise reset with `x` at 1 in the same cycle. It then shows that `z` stays low and that the next 1 starts from IDLE.

The within-cycle Mealy behaviour also needs deliberate stimulus. The bench reaches SAW010 and toggles `x` several times between two edges, checking `z` after each change. The encoding equivalence is covered by driving three instances with one long pseudo-random stream.

// File: rtl/pat0101_det_pkg.sv
package pat0101_det_pkg;

    typedef enum logic [1:0] {
        DET_IDLE   = 2'd0,
        DET_SAW0   = 2'd1,
        DET_SAW01  = 2'd2,
        DET_SAW010 = 2'd3
    } det_state_e;

    localparam int ENC_BINARY = 0;
    localparam int ENC_GRAY   = 1;
    localparam int ENC_ONEHOT = 2;

    function automatic int code_width(input int enc);
        return (enc == ENC_ONEHOT) ? 4 : 2;
    endfunction

endpackage

// File: rtl/det_codec.sv
module det_codec
    import pat0101_det_pkg::*;
#(
    parameter int ENC_SEL = ENC_BINARY,
    parameter int CW      = code_width(ENC_SEL)
) (
    input  det_state_e        log_in,
    output logic [CW-1:0]     code_out,
    input  logic [CW-1:0]     code_in,
    output det_state_e        log_out
);

    generate
        if (ENC_SEL == ENC_ONEHOT) begin : g_onehot
            always_comb begin
                unique case (log_in)
                    DET_IDLE:   code_out = 4'b1000;
                    DET_SAW0:   code_out = 4'b0100;
                    DET_SAW01:  code_out = 4'b0010;
                    DET_SAW010: code_out = 4'b0001;
                    default:    code_out = 4'b1000;
                endcase
            end
            always_comb begin
                case (code_in)
                    4'b0100: log_out = DET_SAW0;
                    4'b0010: log_out = DET_SAW01;
                    4'b0001: log_out = DET_SAW010;
                    default: log_out = DET_IDLE;
                endcase
            end
        end else if (ENC_SEL == ENC_GRAY) begin : g_gray
            logic [1:0] bin_in;
            logic [1:0] bin_out;
            always_comb begin
                bin_in   = log_in;
                code_out = {bin_in[1], bin_in[1] ^ bin_in[0]};
                bin_out  = {code_in[1], code_in[1] ^ code_in[0]};
                log_out  = det_state_e'(bin_out);
            end
        end else begin : g_binary
            always_comb begin
                code_out = log_in;
                log_out  = det_state_e'(code_in);
            end
        end
    endgenerate

endmodule

// File: rtl/det_next.sv
module det_next
    import pat0101_det_pkg::*;
(
    input  det_state_e cur,
    input  logic       bit_in,
    output det_state_e nxt
);

    always_comb begin
        nxt = DET_IDLE;
        unique case (cur)
            DET_IDLE:   nxt = bit_in ? DET_IDLE  : DET_SAW0;
            DET_SAW0:   nxt = bit_in ? DET_SAW01 : DET_SAW0;
            DET_SAW01:  nxt = bit_in ? DET_IDLE  : DET_SAW010;
            DET_SAW010: nxt = bit_in ? DET_SAW01 : DET_SAW0;
            default:    nxt = DET_IDLE;
        endcase
    end

endmodule

// File: rtl/det_out.sv
module det_out
    import pat0101_det_pkg::*;
(
    input  logic       rst,
    input  det_state_e cur,
    input  logic       bit_in,
    output logic       hit
);

    always_comb begin
        hit = 1'b0;
        unique case (cur)
            DET_SAW010: hit = bit_in & ~rst;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pat0101_det.sv
module pat0101_det
    import pat0101_det_pkg::*;
#(
    parameter int ENC_SEL = ENC_BINARY
) (
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic z
);

    localparam int CW = code_width(ENC_SEL);
    localparam logic [CW-1:0] IDLE_CODE =
        (ENC_SEL == ENC_ONEHOT) ? CW'(4'b1000) : CW'(0);

    logic [CW-1:0] state_q;
    logic [CW-1:0] state_d;
    det_state_e    cur_state;
    det_state_e    nxt_state;

    det_codec #(.ENC_SEL(ENC_SEL), .CW(CW)) u_codec (
        .log_in  (nxt_state),
        .code_out(state_d),
        .code_in (state_q),
        .log_out (cur_state)
    );

    det_next u_next (
        .cur   (cur_state),
        .bit_in(x),
        .nxt   (nxt_state)
    );

    det_out u_out (
        .rst   (rst),
        .cur   (cur_state),
        .bit_in(x),
        .hit   (z)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE_CODE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pat0101_det_chk.sv
module pat0101_det_chk
    import pat0101_det_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x,
    input logic       z,
    input det_state_e cur
);

    // R1: reset lands in IDLE
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (cur == DET_IDLE));

    // R1: no flag while reset is high
    p_no_hit_in_reset_r1: assert property (@(posedge clk) rst |-> !z);

    // R2: a hit needs the previous bit to be 0, taken out of reset
    p_hit_prev_zero_r2: assert property (@(posedge clk) disable iff (rst)
        z |-> (x && !$past(x) && !$past(rst)));

    // R3: after a hit the machine keeps the trailing 01
    p_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        z |=> (cur == DET_SAW01));

    // R4: ones hold IDLE
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cur == DET_IDLE && x) |=> (cur == DET_IDLE));

    // R5: zeros hold SAW0
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cur == DET_SAW0 && !x) |=> (cur == DET_SAW0));

    // R6: a 1 after 01 falls back to IDLE
    p_saw01_break_r6: assert property (@(posedge clk) disable iff (rst)
        (cur == DET_SAW01 && x) |=> (cur == DET_IDLE));

    // R7: a 0 after 010 falls back to SAW0
    p_saw010_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (cur == DET_SAW010 && !x) |=> (cur == DET_SAW0));

endmodule

bind pat0101_det pat0101_det_chk u_chk (
    .clk(clk),
    .rst(rst),
    .x  (x),
    .z  (z),
    .cur(cur_state)
);

// File: tb/pat0101_det_bench.sv
`timescale 1ns/1ps
module pat0101_det_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic z_bin, z_gray, z_hot;

    int n_checks = 0;
    int n_errors = 0;
    logic [2:0] hist = 3'b000;
    int nbits = 0;
    int hits_seen = 0;

    always #2.5 clk = ~clk;

    pat0101_det #(.ENC_SEL(0)) u_pat0101_det      (.clk(clk), .rst(rst), .x(x), .z(z_bin));
    pat0101_det #(.ENC_SEL(1)) u_pat0101_det_gray (.clk(clk), .rst(rst), .x(x), .z(z_gray));
    pat0101_det #(.ENC_SEL(2)) u_pat0101_det_hot  (.clk(clk), .rst(rst), .x(x), .z(z_hot));

    task automatic check(input logic ok, input string req, input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive after the falling edge, sample before the rising edge.
    task automatic cyc(input logic r, input logic b, input string req, output logic got);
        logic exp;
        @(negedge clk);
        rst = r;
        x   = b;
        #1;
        exp = !r && (nbits >= 3) && (hist == 3'b010) && b;
        check(z_bin == exp, req, z_bin, exp);
        check(z_gray == exp, {req, " gray R9"}, z_gray, exp);
        check(z_hot == exp, {req, " onehot R9"}, z_hot, exp);
        got = z_bin;
        if (r) begin
            hist  = 3'b000;
            nbits = 0;
        end else begin
            hist  = {hist[1:0], b};
            nbits = nbits + 1;
        end
    endtask

    task automatic do_reset();
        logic g;
        cyc(1'b1, 1'b0, "R1 reset", g);
        cyc(1'b1, 1'b1, "R1 reset", g);
        check(g == 1'b0, "R1 z low in reset", g, 1'b0);
    endtask

    // Sends a bit string (MSB first, len bits) and checks that hits fall exactly on hit_mask positions.
    task automatic send_seq(input logic [15:0] bits, input int len, input logic [15:0] hit_mask, input string req);
        logic g;
        for (int i = 0; i < len; i++) begin
            cyc(1'b0, bits[len-1-i], req, g);
            check(g == hit_mask[len-1-i], {req, " position"}, g, hit_mask[len-1-i]);
        end
    endtask

    task automatic t_basic();
        do_reset();
        send_seq(16'b0101, 4, 16'b0001, "R2");
    endtask

    task automatic t_overlap();
        do_reset();
        send_seq(16'b0101010, 7, 16'b0001010, "R3");
    endtask

    task automatic t_idle_ones();
        do_reset();
        send_seq(16'b1101, 4, 16'b0000, "R4");
        send_seq(16'b11110101, 8, 16'b00000001, "R4");
    endtask

    task automatic t_zero_run();
        do_reset();
        send_seq(16'b000101, 6, 16'b000001, "R5");
    endtask

    task automatic t_saw01_break();
        do_reset();
        send_seq(16'b01101, 5, 16'b00000, "R6");
        do_reset();
        send_seq(16'b0110101, 7, 16'b0000001, "R6");
    endtask

    task automatic t_saw010_zero();
        do_reset();
        send_seq(16'b0100101, 7, 16'b0000001, "R7");
    endtask

    task automatic t_mealy();
        logic g;
        do_reset();
        send_seq(16'b010, 3, 16'b000, "R8");
        @(negedge clk);
        x = 1'b1; #0.5;
        check(z_bin == 1'b1, "R8 rise with x", z_bin, 1'b1);
        x = 1'b0; #0.5;
        check(z_bin == 1'b0, "R8 fall with x", z_bin, 1'b0);
        check(z_hot == 1'b0, "R8 onehot fall with x", z_hot, 1'b0);
        x = 1'b1; #0.5;
        check(z_gray == 1'b1, "R8 gray rise with x", z_gray, 1'b1);
        // edge consumes 1: now in SAW01 with 0101 taken
        hist  = 3'b101;
        nbits = 4;
        cyc(1'b0, 1'b0, "R8", g);
        cyc(1'b0, 1'b1, "R8", g);
        check(g == 1'b1, "R8 overlap after toggle", g, 1'b1);
    endtask

    task automatic t_reset_pending();
        logic g;
        do_reset();
        send_seq(16'b010, 3, 16'b000, "R1");
        cyc(1'b1, 1'b1, "R1 pending", g);
        check(g == 1'b0, "R1 masked pending hit", g, 1'b0);
        cyc(1'b0, 1'b1, "R1 idle after reset", g);
        check(g == 1'b0, "R1 idle after reset", g, 1'b0);
        send_seq(16'b0101, 4, 16'b0001, "R1");
    endtask

    task automatic t_stream();
        logic [15:0] lfsr = 16'hACE1;
        logic g;
        int hits = 0;
        do_reset();
        for (int i = 0; i < 600; i++) begin
            cyc(1'b0, lfsr[0], "R9 stream", g);
            if (g) hits++;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        hits_seen = hits;
        check(hits > 0, "R9 stream produced hits", hits > 0, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_basic();
        t_overlap();
        t_idle_ones();
        t_zero_run();
        t_saw01_break();
        t_saw010_zero();
        t_mealy();
        t_reset_pending();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule